// File: doc/BRIEF.md
# Egress Candidate Picker

One instance of this block sits beside each egress port of a packet switch. Each cycle it looks at the head TLPs that every ingress port offers. The kinds are posted, non-posted, completion and insertion. It marks in a candidate vector the ingress ports that hold a TLP this egress port could accept right now. The downstream bus arbiter grants among the set bits. Crediting and arbitration state are kept elsewhere. The picker only reads them.

A head qualifies in one of two ways. If it is bound for the link, it must fit in both the output buffer and the replay buffer, and the link partner must have advertised enough header and data credit for its flow-control class. If it is consumed by this port's own application layer, that layer must be ready to take it. Only heads that the ingress ordering logic reports as valid count. The whole vector is held off while the bus decoupler queue is full. For each candidate port the picker also reports which head kind to send: the oldest qualifying head.

Top module: `egress_pick`

## Requirements
- R1: While `rst_n` is low, `cand` and `cand_kind` are all zero. Both outputs are registered, so a change of inputs appears after the next rising clock edge and not before.
- R2: `cand[i]` is set only when ingress port `i` has a head with `hd_vld` set whose `hd_dest` equals `my_port`. Kind index codes are 0 posted, 1 non-posted, 2 completion, 3 insertion.
- R3: A link-bound head (`hd_local` clear) needs `1 + ceil(len/16)` blocks of 16 bytes. Both `obuf_free` and `rbuf_free` must be at least that count; `len` is the payload in bytes.
- R4: A link-bound head needs at least one header credit and at least `ceil(len/16)` data credits in its class. Index 0 of `hdr_cred`/`dat_cred` is posted, 1 is non-posted and 2 is completion. For insertion heads the class comes from `ins_cls`: 1 is non-posted, 2 is completion, and 0 or 3 is posted.
- R5: A credit field that reads all ones is infinite, and its check always passes.
- R6: A local head (`hd_local` set) qualifies exactly when `app_rdy` is high. Buffer space and credits do not affect it.
- R7: While `dq_occ >= DQ_LIMIT`, every bit of the next `cand` is zero.
- R8: `cand_kind[i]` is the qualifying head with the smallest `hd_age`. On equal ages insertion wins, then the lowest kind code.
- R9: `cand_kind[i]` reads 0 whenever `cand[i]` is clear.
- R10: An older head that fails its checks does not hold back a younger qualifying head of another kind on the same port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_port | input | PID_W | Identifier of this egress port |
| hd_vld | input | NUM_PORTS×4 | Head valid per ingress port and kind |
| hd_dest | input | NUM_PORTS×4×PID_W | Destination port of each head |
| hd_local | input | NUM_PORTS×4 | Head is consumed by the local application layer |
| hd_len | input | NUM_PORTS×4×LEN_W | Payload length in bytes |
| hd_age | input | NUM_PORTS×4×AGE_W | Timestamp, smaller is older |
| ins_cls | input | NUM_PORTS×2 | Credit class of the insertion head |
| obuf_free | input | SP_W | Free output buffer blocks |
| rbuf_free | input | SP_W | Free replay buffer blocks |
| hdr_cred | input | 3×HC_W | Header credits per class |
| dat_cred | input | 3×DC_W | Data credits per class |
| app_rdy | input | 1 | Application layer can accept a TLP |
| dq_occ | input | DQ_W | Bus decoupler queue occupancy |
| cand | output | NUM_PORTS | Candidate vector |
| cand_kind | output | NUM_PORTS×2 | Chosen head kind per candidate port |

## Verification
The interesting overlap is age selection meeting a failed eligibility check in the same cycle. One case uses an older local completion while the application layer is busy. Another uses an older posted head that is short of data credit. In both, a younger head on the same port must become the chosen kind. This is provoked by directed cases that then flip the blocking condition and expect the kind to revert. A randomized phase produces many more such collisions, together with decoupler suppression. Every bit and kind is judged against a reference model written from the requirements.

// File: rtl/egress_pick_pkg.sv
package egress_pick_pkg;
  typedef enum logic [1:0] {
    KIND_P   = 2'd0,
    KIND_NP  = 2'd1,
    KIND_CP  = 2'd2,
    KIND_INS = 2'd3
  } tlp_kind_e;

  localparam int NUM_KINDS = 4;
  localparam int NUM_CLS   = 3;
  localparam int BLK_SHIFT = 4;   // 16-byte blocks
  localparam int HDR_BLKS  = 1;   // header occupies one block
endpackage

// File: rtl/epk_head_elig.sv
module epk_head_elig
  import egress_pick_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int SP_W  = 8,
  parameter int HC_W  = 8,
  parameter int DC_W  = 12,
  parameter int PID_W = 2
) (
  input  logic             vld,
  input  logic [PID_W-1:0] dest,
  input  logic             is_local,
  input  logic [LEN_W-1:0] len,
  input  logic [PID_W-1:0] my_port,
  input  logic [SP_W-1:0]  obuf_free,
  input  logic [SP_W-1:0]  rbuf_free,
  input  logic [HC_W-1:0]  hcred,
  input  logic [DC_W-1:0]  dcred,
  input  logic             app_rdy,
  output logic             ok
);
  localparam int DW  = LEN_W - BLK_SHIFT + 1;
  localparam int CW0 = (SP_W > DC_W) ? SP_W : DC_W;
  localparam int CW  = (CW0 > DW + 1) ? CW0 : DW + 1;

  logic [LEN_W:0]  len_rnd;
  logic [DW-1:0]   dblk;
  logic [CW-1:0]   need_blk;
  logic            space_ok;
  logic            hc_ok;
  logic            dc_ok;
  logic            link_ok;

  assign len_rnd  = {1'b0, len} + (LEN_W+1)'((1 << BLK_SHIFT) - 1);
  assign dblk     = len_rnd[LEN_W:BLK_SHIFT];
  assign need_blk = CW'(dblk) + CW'(HDR_BLKS);

  assign space_ok = (CW'(obuf_free) >= need_blk) && (CW'(rbuf_free) >= need_blk);
  assign hc_ok    = (&hcred) || (hcred != '0);
  assign dc_ok    = (&dcred) || (CW'(dcred) >= CW'(dblk));
  assign link_ok  = space_ok && hc_ok && dc_ok;

  assign ok = vld && (dest == my_port) && (is_local ? app_rdy : link_ok);
endmodule

// File: rtl/epk_oldest_sel.sv
module epk_oldest_sel
  import egress_pick_pkg::*;
#(
  parameter int AGE_W = 8
) (
  input  logic [NUM_KINDS-1:0]            elig,
  input  logic [NUM_KINDS-1:0][AGE_W-1:0] age,
  output logic                            any,
  output logic [1:0]                      kind
);
  logic             found;
  logic [1:0]       best;
  logic [AGE_W-1:0] best_age;

  // insertion is examined first; later kinds replace only when strictly older
  always_comb begin
    found    = elig[KIND_INS];
    best     = KIND_INS;
    best_age = age[KIND_INS];
    for (int k = 0; k < NUM_KINDS - 1; k++) begin
      if (elig[k] && (!found || (age[k] < best_age))) begin
        found    = 1'b1;
        best     = 2'(k);
        best_age = age[k];
      end
    end
  end

  assign any  = found;
  assign kind = found ? best : 2'd0;
endmodule

// File: rtl/egress_pick.sv
module egress_pick
  import egress_pick_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int LEN_W     = 10,
  parameter int AGE_W     = 8,
  parameter int SP_W      = 8,
  parameter int HC_W      = 8,
  parameter int DC_W      = 12,
  parameter int DQ_LIMIT  = 8,
  localparam int PID_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int DQ_W     = $clog2(DQ_LIMIT + 1)
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic [PID_W-1:0]                               my_port,
  input  logic [NUM_PORTS-1:0][NUM_KINDS-1:0]            hd_vld,
  input  logic [NUM_PORTS-1:0][NUM_KINDS-1:0][PID_W-1:0] hd_dest,
  input  logic [NUM_PORTS-1:0][NUM_KINDS-1:0]            hd_local,
  input  logic [NUM_PORTS-1:0][NUM_KINDS-1:0][LEN_W-1:0] hd_len,
  input  logic [NUM_PORTS-1:0][NUM_KINDS-1:0][AGE_W-1:0] hd_age,
  input  logic [NUM_PORTS-1:0][1:0]                      ins_cls,
  input  logic [SP_W-1:0]                                obuf_free,
  input  logic [SP_W-1:0]                                rbuf_free,
  input  logic [NUM_CLS-1:0][HC_W-1:0]                   hdr_cred,
  input  logic [NUM_CLS-1:0][DC_W-1:0]                   dat_cred,
  input  logic                                           app_rdy,
  input  logic [DQ_W-1:0]                                dq_occ,
  output logic [NUM_PORTS-1:0]                           cand,
  output logic [NUM_PORTS-1:0][1:0]                      cand_kind
);
  logic [NUM_PORTS-1:0]      pick_any;
  logic [NUM_PORTS-1:0][1:0] pick_kind;
  logic                      dq_ok;
  logic [NUM_PORTS-1:0]      cand_d;
  logic [NUM_PORTS-1:0][1:0] kind_d;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic [NUM_KINDS-1:0] elig;

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      logic [1:0] cls;
      if (k < NUM_CLS) begin : g_fixed
        assign cls = 2'(k);
      end else begin : g_ins
        assign cls = ((ins_cls[i] == 2'd1) || (ins_cls[i] == 2'd2)) ? ins_cls[i] : 2'd0;
      end

      epk_head_elig #(
        .LEN_W (LEN_W),
        .SP_W  (SP_W),
        .HC_W  (HC_W),
        .DC_W  (DC_W),
        .PID_W (PID_W)
      ) u_elig (
        .vld       (hd_vld[i][k]),
        .dest      (hd_dest[i][k]),
        .is_local  (hd_local[i][k]),
        .len       (hd_len[i][k]),
        .my_port   (my_port),
        .obuf_free (obuf_free),
        .rbuf_free (rbuf_free),
        .hcred     (hdr_cred[cls]),
        .dcred     (dat_cred[cls]),
        .app_rdy   (app_rdy),
        .ok        (elig[k])
      );
    end

    epk_oldest_sel #(
      .AGE_W (AGE_W)
    ) u_sel (
      .elig (elig),
      .age  (hd_age[i]),
      .any  (pick_any[i]),
      .kind (pick_kind[i])
    );
  end

  assign dq_ok = (dq_occ < DQ_W'(DQ_LIMIT));

  // next state
  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      cand_d[i] = pick_any[i] && dq_ok;
      kind_d[i] = cand_d[i] ? pick_kind[i] : 2'd0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand      <= '0;
      cand_kind <= '0;
    end else begin
      cand      <= cand_d;
      cand_kind <= kind_d;
    end
  end
endmodule

// File: rtl/egress_pick_chk.sv
module egress_pick_chk
  import egress_pick_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int DQ_LIMIT  = 8,
  parameter int SP_W      = 8,
  parameter int PID_W     = 2,
  parameter int DQ_W      = 4
) (
  input logic                                           clk,
  input logic                                           rst_n,
  input logic [PID_W-1:0]                               my_port,
  input logic [NUM_PORTS-1:0][NUM_KINDS-1:0]            hd_vld,
  input logic [NUM_PORTS-1:0][NUM_KINDS-1:0][PID_W-1:0] hd_dest,
  input logic [NUM_PORTS-1:0][NUM_KINDS-1:0]            hd_local,
  input logic [SP_W-1:0]                                obuf_free,
  input logic [SP_W-1:0]                                rbuf_free,
  input logic                                           app_rdy,
  input logic [DQ_W-1:0]                                dq_occ,
  input logic [NUM_PORTS-1:0]                           cand,
  input logic [NUM_PORTS-1:0][1:0]                      cand_kind
);
  p_rst_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (cand == '0) && (cand_kind == '0));

  p_dq_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_occ >= DQ_W'(DQ_LIMIT)) |=> (cand == '0));

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_p
    p_kind_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cand[i] |-> (cand_kind[i] == 2'd0));

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_k
      p_head_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cand[i] && (cand_kind[i] == 2'(k))) |->
          $past(hd_vld[i][k] && (hd_dest[i][k] == my_port)));

      p_local_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cand[i] && (cand_kind[i] == 2'(k))) |->
          $past(!hd_local[i][k] || app_rdy));

      p_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cand[i] && (cand_kind[i] == 2'(k))) |->
          $past(hd_local[i][k] || ((obuf_free != '0) && (rbuf_free != '0))));
    end
  end
endmodule

bind egress_pick egress_pick_chk #(
  .NUM_PORTS (NUM_PORTS),
  .DQ_LIMIT  (DQ_LIMIT),
  .SP_W      (SP_W),
  .PID_W     (PID_W),
  .DQ_W      (DQ_W)
) u_chk (.*);

// File: tb/tb_egress_pick.sv
`timescale 1ns/1ps
module tb_egress_pick;
  localparam int N     = 3;
  localparam int K     = 4;
  localparam int LEN_W = 10;
  localparam int AGE_W = 8;
  localparam int SP_W  = 8;
  localparam int HC_W  = 8;
  localparam int DC_W  = 12;
  localparam int DQL   = 8;
  localparam int PID_W = 2;
  localparam int DQ_W  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [PID_W-1:0]                 my_port;
  logic [N-1:0][K-1:0]              hd_vld;
  logic [N-1:0][K-1:0][PID_W-1:0]   hd_dest;
  logic [N-1:0][K-1:0]              hd_local;
  logic [N-1:0][K-1:0][LEN_W-1:0]   hd_len;
  logic [N-1:0][K-1:0][AGE_W-1:0]   hd_age;
  logic [N-1:0][1:0]                ins_cls;
  logic [SP_W-1:0]                  obuf_free, rbuf_free;
  logic [2:0][HC_W-1:0]             hdr_cred;
  logic [2:0][DC_W-1:0]             dat_cred;
  logic                             app_rdy;
  logic [DQ_W-1:0]                  dq_occ;
  logic [N-1:0]                     cand;
  logic [N-1:0][1:0]                cand_kind;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  egress_pick dut (
    .clk, .rst_n, .my_port, .hd_vld, .hd_dest, .hd_local, .hd_len, .hd_age,
    .ins_cls, .obuf_free, .rbuf_free, .hdr_cred, .dat_cred, .app_rdy,
    .dq_occ, .cand, .cand_kind
  );

  // rows: obuf, rbuf, hdr credit, data credit, app_rdy, dq_occ, expected cand
  localparam logic [43:0] TBL [10] = '{
    {8'd10, 8'd10, 8'd5,   12'd10,    1'b1, 4'd0, 3'b111},
    {8'd2,  8'd10, 8'd5,   12'd10,    1'b1, 4'd0, 3'b110},
    {8'd3,  8'd3,  8'd5,   12'd10,    1'b1, 4'd0, 3'b111},
    {8'd10, 8'd0,  8'd5,   12'd10,    1'b1, 4'd0, 3'b100},
    {8'd10, 8'd10, 8'd0,   12'd10,    1'b1, 4'd0, 3'b100},
    {8'd10, 8'd10, 8'hFF,  12'd1,     1'b1, 4'd0, 3'b110},
    {8'd10, 8'd10, 8'd1,   12'hFFF,   1'b1, 4'd0, 3'b111},
    {8'd10, 8'd10, 8'd5,   12'd10,    1'b0, 4'd0, 3'b011},
    {8'd10, 8'd10, 8'd5,   12'd10,    1'b1, 4'd8, 3'b000},
    {8'd10, 8'd10, 8'd5,   12'd10,    1'b1, 4'd7, 3'b111}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_heads();
    hd_vld = '0; hd_dest = '0; hd_local = '0; hd_len = '0; hd_age = '0; ins_cls = '0;
  endtask

  task automatic set_res(int ob, int rb, int hc, int dc, bit ar, int dq);
    obuf_free = SP_W'(ob); rbuf_free = SP_W'(rb);
    for (int c = 0; c < 3; c++) begin
      hdr_cred[c] = HC_W'(hc);
      dat_cred[c] = DC_W'(dc);
    end
    app_rdy = ar; dq_occ = DQ_W'(dq);
  endtask

  task automatic put(int p, int k, int dst, bit loc, int len, int age);
    hd_vld[p][k] = 1'b1; hd_dest[p][k] = PID_W'(dst); hd_local[p][k] = loc;
    hd_len[p][k] = LEN_W'(len); hd_age[p][k] = AGE_W'(age);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // independent model of the requirements
  function automatic bit head_ok(int p, int k);
    int dblk, blks, cls;
    if (!hd_vld[p][k] || hd_dest[p][k] != my_port) return 1'b0;
    if (hd_local[p][k]) return app_rdy;
    dblk = (int'(hd_len[p][k]) + 15) / 16;
    blks = dblk + 1;
    if (k < 3) cls = k;
    else if (ins_cls[p] == 2'd1) cls = 1;
    else if (ins_cls[p] == 2'd2) cls = 2;
    else cls = 0;
    if (int'(obuf_free) < blks || int'(rbuf_free) < blks) return 1'b0;
    if (hdr_cred[cls] != {HC_W{1'b1}} && hdr_cred[cls] == 0) return 1'b0;
    if (dat_cred[cls] != {DC_W{1'b1}} && int'(dat_cred[cls]) < dblk) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_check(string tag);
    int order [4] = '{3, 0, 1, 2};
    for (int p = 0; p < N; p++) begin
      bit got = 0; int bk = 0; int ba = 0;
      for (int j = 0; j < 4; j++) begin
        int k = order[j];
        if (head_ok(p, k) && (!got || int'(hd_age[p][k]) < ba)) begin
          got = 1; bk = k; ba = int'(hd_age[p][k]);
        end
      end
      if (int'(dq_occ) >= DQL) got = 0;
      if (!got) bk = 0;
      step_pending_exp[p] = got;
      step_pending_kind[p] = bk;
    end
    step();
    for (int p = 0; p < N; p++) begin
      check({tag, " R2/R3/R4/R5/R6/R7 cand"}, int'(cand[p]), int'(step_pending_exp[p]));
      check({tag, " R8/R9 kind"}, int'(cand_kind[p]), step_pending_kind[p]);
    end
  endtask

  bit step_pending_exp [N];
  int step_pending_kind [N];

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    my_port = '0;
    clear_heads();
    set_res(10, 10, 5, 10, 1'b1, 0);
    put(0, 0, 0, 1'b0, 0, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: held at zero in reset despite eligible heads
    check("R1 reset cand", int'(cand), 0);
    check("R1 reset kind", int'(cand_kind), 0);
    rst_n = 1'b1;
    #1;
    check("R1 no output before edge", int'(cand), 0);
    @(negedge clk);
    check("R1 output after first edge", int'(cand), 1);

    // table walk: port0 posted link 32B, port1 non-posted link 0B, port2 local completion 64B
    clear_heads();
    put(0, 0, 0, 1'b0, 32, 1);
    put(1, 1, 0, 1'b0, 0, 2);
    put(2, 2, 0, 1'b1, 64, 3);
    foreach (TBL[r]) begin
      logic [43:0] row = TBL[r];
      set_res(int'(row[43:36]), int'(row[35:28]), int'(row[27:20]),
              int'(row[19:8]), row[7], int'(row[6:3]));
      step();
      check($sformatf("R3/R4/R5/R6/R7 table row %0d", r), int'(cand), int'(row[2:0]));
      for (int p = 0; p < N; p++)
        check($sformatf("R9 table row %0d kind", r), int'(cand_kind[p]), row[p] ? p : 0);
    end

    // R8: tie between posted and insertion goes to insertion
    clear_heads(); set_res(10, 10, 5, 10, 1'b1, 0);
    put(0, 0, 0, 1'b0, 0, 5);
    put(0, 3, 0, 1'b0, 0, 5);
    step();
    check("R8 tie kind", int'(cand_kind[0]), 3);
    hd_age[0][0] = 8'd3;
    step();
    check("R8 older posted kind", int'(cand_kind[0]), 0);

    // R10/R4: older posted lacks data credit, younger insertion on completion class goes
    hd_len[0][0] = 10'd64;
    dat_cred[0] = 12'd2;
    ins_cls[0] = 2'd2;
    step();
    check("R10 cand", int'(cand[0]), 1);
    check("R10 kind", int'(cand_kind[0]), 3);

    // R4: insertion class 3 uses posted credits
    clear_heads(); set_res(10, 10, 5, 10, 1'b1, 0);
    hdr_cred[0] = 8'd0;
    put(0, 3, 0, 1'b0, 0, 1);
    ins_cls[0] = 2'd3;
    step();
    check("R4 class3 posted credit", int'(cand[0]), 0);
    ins_cls[0] = 2'd1;
    step();
    check("R4 class1 non-posted credit", int'(cand[0]), 1);

    // R2: destination mismatch, then matching egress id
    clear_heads(); set_res(10, 10, 5, 10, 1'b1, 0);
    put(1, 0, 1, 1'b0, 0, 1);
    step();
    check("R2 other dest", int'(cand), 0);
    my_port = 2'd1;
    step();
    check("R2 matching dest", int'(cand), 2);
    my_port = 2'd0;

    // R6/R10: older local completion blocked by app layer, younger non-posted link head
    clear_heads(); set_res(10, 10, 5, 10, 1'b0, 0);
    put(0, 2, 0, 1'b1, 64, 1);
    put(0, 1, 0, 1'b0, 0, 4);
    step();
    check("R6 app busy kind", int'(cand_kind[0]), 1);
    app_rdy = 1'b1;
    obuf_free = '0; hdr_cred = '0;
    step();
    check("R6 local ignores space and credit", int'(cand[0]), 1);
    check("R6 local chosen kind", int'(cand_kind[0]), 2);

    // R3/R5: boundary at 1008 bytes = 63 data blocks + header
    clear_heads(); set_res(64, 64, 5, 63, 1'b1, 0);
    put(0, 0, 0, 1'b0, 1008, 1);
    step();
    check("R3 exact fit", int'(cand[0]), 1);
    obuf_free = 8'd63;
    step();
    check("R3 one block short", int'(cand[0]), 0);
    obuf_free = 8'd64; dat_cred[0] = 12'd62;
    step();
    check("R4 one data credit short", int'(cand[0]), 0);
    dat_cred[0] = 12'hFFF;
    step();
    check("R5 infinite data credit", int'(cand[0]), 1);

    // randomized states against the model
    for (int it = 0; it < 400; it++) begin
      clear_heads();
      my_port = PID_W'($urandom % 3);
      for (int p = 0; p < N; p++) begin
        ins_cls[p] = 2'($urandom % 4);
        for (int k = 0; k < K; k++) begin
          hd_vld[p][k]   = 1'($urandom % 2);
          hd_dest[p][k]  = PID_W'($urandom % 3);
          hd_local[p][k] = ($urandom % 4) == 0;
          hd_len[p][k]   = LEN_W'($urandom % 97);
          hd_age[p][k]   = AGE_W'($urandom % 12);
        end
      end
      obuf_free = SP_W'($urandom % 9);
      rbuf_free = SP_W'($urandom % 9);
      for (int c = 0; c < 3; c++) begin
        hdr_cred[c] = (($urandom % 5) == 0) ? {HC_W{1'b1}} : HC_W'($urandom % 3);
        dat_cred[c] = (($urandom % 5) == 0) ? {DC_W{1'b1}} : DC_W'($urandom % 8);
      end
      app_rdy = 1'($urandom % 2);
      dq_occ  = DQ_W'($urandom % 10);
      model_check("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule